// File: doc/BRIEF.md
# Asynchronous Serial Port with Frame-Marker Bit

This block is a full-duplex asynchronous serial port with a byte-wide register bus. Each character carries an extra marker bit. A marker of 1 tells a listener on a shared line that this character opens a new message. The receiver keeps the most recent marker value and raises a first-byte-of-message flag. Both flags clear when software reads the received byte.

The transmitter and receiver have separate enables. The transmitter can also be held off by an active-low clear-to-send input. Parity is optional, and its sense can be even or odd. The control bits also select:
- a second stop bit;
- a line-break mode that forces the output low;
- an internal loopback that routes the serial output into the receiver.

All timing comes from a 16-bit divisor that produces a 16x oversampling tick. The receiver samples the middle of each bit. It reports parity and framing errors.

Software changes a control register only while the port is disabled. The single write allowed while the port is enabled is a write of zero to the main control register. This is how the port is disabled before it is reconfigured.

Top module: `uart_mp`

## Requirements
- R1: After reset, the control register (address 2), the extra control register (address 5) and the status register (address 1) read 0, `txd` is 1 and `rx_ready` is 0.
- R2: A character starts only when control bit 0 (transmit enable) is 1 and, if control bit 2 (clear-to-send gating) is 1, `cts_n` is also 0. Otherwise a written byte stays held and status bit 1 (holding full) reads 1. A character already on the line always completes.
- R3: With control bit 2 at 0, `cts_n` has no effect on transmission.
- R4: With control bit 3 at 1, a parity bit is sent and expected. Control bit 4 at 0 selects even parity, where data plus parity hold an even number of ones; at 1 it selects odd parity. A received mismatch sets status bit 5. With control bit 3 at 0, no parity bit exists.
- R5: Line order: one start bit (0), then 8 data bits LSB first, then the parity bit if enabled, then the marker bit, then one stop bit (1), or two when control bit 6 is 1. Writing address 0 sends with marker 0; writing address 6 sends with marker 1.
- R6: On reception, status bit 0 (byte ready, also on `rx_ready`) is set. Status bit 4 holds the received marker bit, and status bit 3 (first byte of message) is 1 when that marker is 1. Reading address 0 returns the byte and clears status bits 0, 3, 4, 5 and 6.
- R7: While control bit 5 is 1, `txd` is 0, whatever the enables are.
- R8: With extra-control bit 0 at 1, the receiver takes its input from the port's own serial output, and activity on `rxd` has no effect.
- R9: A stop bit sampled as 0 sets status bit 6 (framing error).
- R10: Reserved bits read as 0: control bit 7 and extra-control bits 7..1, even after writing 1 to them.
- R11: With control bit 1 (receive enable) at 0, no byte is received and `rx_ready` stays 0.
- R12: One bit lasts 16 × max(divisor, 1) clock cycles. Address 3 holds the divisor's low byte and address 4 its high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 0 clears the receive status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear-to-send, active low |
| rx_ready | output | 1 | A received byte is waiting |

## Verification
A clear-to-send release can land in the same cycle that a character is already on the line, while a second byte waits in the holding register. The bench queues two bytes with gating active and raises `cts_n` once the first character is shifting. It then checks that the scoreboard receives the first byte intact through loopback. It also checks that the second byte stays queued, with status bit 1 set, until `cts_n` falls again. Direct bit-banged frames on `rxd` judge the receive side independently of the transmitter: line order, parity sense and framing errors.

// File: rtl/uart_mp_pkg.sv
// Shared constants and state types for the marker-bit serial port.
// Assumes an 8-bit register bus and a 16-bit baud divisor.
package uart_mp_pkg;
    localparam int DW   = 8;    // data bits per character
    localparam int OSR  = 16;   // oversampling ticks per bit
    localparam int DIVW = 16;   // baud divisor width
    localparam int AW   = 3;    // register address width

    localparam logic [AW-1:0] A_DATA  = 3'd0;
    localparam logic [AW-1:0] A_STAT  = 3'd1;
    localparam logic [AW-1:0] A_CTRL  = 3'd2;
    localparam logic [AW-1:0] A_DIVL  = 3'd3;
    localparam logic [AW-1:0] A_DIVH  = 3'd4;
    localparam logic [AW-1:0] A_CTRLX = 3'd5;
    localparam logic [AW-1:0] A_MARK  = 3'd6;

    // control register bit positions
    localparam int C_TXEN = 0;
    localparam int C_RXEN = 1;
    localparam int C_CTSG = 2;
    localparam int C_PAR  = 3;
    localparam int C_ODD  = 4;
    localparam int C_BRK  = 5;
    localparam int C_STP2 = 6;
    localparam int CTRL_W = 7;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_MARK, TX_STOP1, TX_STOP2
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_MARK, RX_STOP
    } rx_state_e;
endpackage

// File: rtl/uart_mp_baud.sv
// Oversampling tick generator: one-cycle tick every max(divisor,1) clocks.
// Assumes the divisor changes only while the port is disabled.
module uart_mp_baud #(
    parameter int DIVW = uart_mp_pkg::DIVW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] divisor,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    // counts up to the divisor and emits a tick on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (({1'b0, cnt} + 1'b1) >= {1'b0, divisor}) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R12
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > 1) |=> !tick)
        else $error("tick_spacing_chk");
endmodule

// File: rtl/uart_mp_tx.sv
// Transmitter: one holding byte plus a shifter. It sends start, data LSB first,
// optional parity, the marker bit and one or two stop bits, 16 ticks per bit.
// Assumes format inputs are stable while a character is on the line.
module uart_mp_tx
    import uart_mp_pkg::*;
#(
    parameter int DW  = uart_mp_pkg::DW,
    parameter int OSR = uart_mp_pkg::OSR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          permit,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          two_stop,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          load_mark,
    output logic          hold_full,
    output logic          active,
    output logic          line
);
    localparam int SUBW = $clog2(OSR);
    localparam int BITW = $clog2(DW);

    tx_state_e       state;
    logic [DW-1:0]   hold_q, sh;
    logic            hold_mark, mark_q, par_q;
    logic [SUBW-1:0] sub;
    logic [BITW-1:0] bitn;

    assign active = (state != TX_IDLE);

    // holding register, start decision and serial sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= TX_IDLE;
            hold_q    <= '0;
            hold_mark <= 1'b0;
            hold_full <= 1'b0;
            sh        <= '0;
            mark_q    <= 1'b0;
            par_q     <= 1'b0;
            sub       <= '0;
            bitn      <= '0;
            line      <= 1'b1;
        end else begin
            if (load && !hold_full) begin
                hold_q    <= load_data;
                hold_mark <= load_mark;
                hold_full <= 1'b1;
            end
            if (tick) begin
                if (state == TX_IDLE) begin
                    if (hold_full && permit) begin
                        sh        <= hold_q;
                        mark_q    <= hold_mark;
                        par_q     <= (^hold_q) ^ par_odd;
                        hold_full <= 1'b0;
                        state     <= TX_START;
                        sub       <= '0;
                        line      <= 1'b0;
                    end
                end else if (sub != SUBW'(OSR - 1)) begin
                    sub <= sub + 1'b1;
                end else begin
                    sub <= '0;
                    unique case (state)
                        TX_START: begin
                            state <= TX_DATA;
                            bitn  <= '0;
                            line  <= sh[0];
                        end
                        TX_DATA: begin
                            if (bitn == BITW'(DW - 1)) begin
                                state <= par_en ? TX_PAR : TX_MARK;
                                line  <= par_en ? par_q : mark_q;
                            end else begin
                                bitn <= bitn + 1'b1;
                                sh   <= sh >> 1;
                                line <= sh[1];
                            end
                        end
                        TX_PAR: begin
                            state <= TX_MARK;
                            line  <= mark_q;
                        end
                        TX_MARK: begin
                            state <= TX_STOP1;
                            line  <= 1'b1;
                        end
                        TX_STOP1: state <= two_stop ? TX_STOP2 : TX_IDLE;
                        default:  state <= TX_IDLE;
                    endcase
                end
            end
        end
    end

    // R2
    tx_start_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(permit))
        else $error("tx_start_permit_chk");

    // R2
    tx_hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !permit) |=> hold_full)
        else $error("tx_hold_kept_chk");
endmodule

// File: rtl/uart_mp_rx.sv
// Receiver: finds a start edge, confirms it at mid start bit, then samples
// every following bit at mid-bit. It pulses deliver with byte, marker and error flags.
// Assumes a line that is already synchronized to clk.
module uart_mp_rx
    import uart_mp_pkg::*;
#(
    parameter int DW  = uart_mp_pkg::DW,
    parameter int OSR = uart_mp_pkg::OSR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          line,
    output logic          deliver,
    output logic [DW-1:0] data,
    output logic          mark,
    output logic          perr,
    output logic          ferr
);
    localparam int SUBW = $clog2(OSR);
    localparam int BITW = $clog2(DW);

    rx_state_e       state;
    logic [DW-1:0]   sh;
    logic            pbit, mark_r;
    logic [SUBW-1:0] sub;
    logic [BITW-1:0] bitn;

    // bit-time sequencing and mid-bit sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            sh      <= '0;
            pbit    <= 1'b0;
            mark_r  <= 1'b0;
            sub     <= '0;
            bitn    <= '0;
            deliver <= 1'b0;
            data    <= '0;
            mark    <= 1'b0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
        end else begin
            deliver <= 1'b0;
            if (!enable) begin
                state <= RX_IDLE;
            end else if (tick) begin
                if (state == RX_IDLE) begin
                    if (!line) begin
                        state <= RX_START;
                        sub   <= '0;
                    end
                end else if (state == RX_START) begin
                    if (sub == SUBW'(OSR / 2 - 1)) begin
                        sub   <= '0;
                        bitn  <= '0;
                        state <= line ? RX_IDLE : RX_DATA;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end else if (sub != SUBW'(OSR - 1)) begin
                    sub <= sub + 1'b1;
                end else begin
                    sub <= '0;
                    unique case (state)
                        RX_DATA: begin
                            sh <= {line, sh[DW-1:1]};
                            if (bitn == BITW'(DW - 1))
                                state <= par_en ? RX_PAR : RX_MARK;
                            else
                                bitn <= bitn + 1'b1;
                        end
                        RX_PAR: begin
                            pbit  <= line;
                            state <= RX_MARK;
                        end
                        RX_MARK: begin
                            mark_r <= line;
                            state  <= RX_STOP;
                        end
                        default: begin
                            deliver <= 1'b1;
                            data    <= sh;
                            mark    <= mark_r;
                            perr    <= par_en && ((^sh) ^ pbit ^ par_odd);
                            ferr    <= !line;
                            state   <= RX_IDLE;
                        end
                    endcase
                end
            end
        end
    end

    // R11
    rx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == RX_IDLE && !deliver))
        else $error("rx_off_idle_chk");
endmodule

// File: rtl/uart_mp.sv
// Top: register bus, control and status registers, input synchronizer,
// loopback select and break forcing around the baud, tx and rx units.
// Assumes software writes control registers only while the port is disabled.
module uart_mp
    import uart_mp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          rxd,
    output logic          txd,
    input  logic          cts_n,
    output logic          rx_ready
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              loop_q;
    logic [DIVW-1:0]   div_q;
    logic              tick, permit, tx_load, hold_full, tx_active, tx_line;
    logic              rx_deliver, rx_mark, rx_perr, rx_ferr, rx_line;
    logic [DW-1:0]     rx_byte, rx_data_q;
    logic              rx_valid_q, new_frame_q, mark_last_q, perr_q, ferr_q;
    logic [1:0]        rxd_sync;
    logic              rd_data;

    assign permit   = ctrl_q[C_TXEN] && !(ctrl_q[C_CTSG] && cts_n);
    assign tx_load  = reg_wr && (reg_addr == A_DATA || reg_addr == A_MARK);
    assign rd_data  = reg_rd && (reg_addr == A_DATA);
    assign rx_line  = loop_q ? txd : rxd_sync[1];
    assign rx_ready = rx_valid_q;

    uart_mp_baud #(.DIVW(DIVW)) i_baud (
        .clk(clk), .rst_n(rst_n), .divisor(div_q), .tick(tick)
    );

    uart_mp_tx #(.DW(DW), .OSR(OSR)) i_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .permit(permit),
        .par_en(ctrl_q[C_PAR]), .par_odd(ctrl_q[C_ODD]), .two_stop(ctrl_q[C_STP2]),
        .load(tx_load), .load_data(reg_wdata), .load_mark(reg_addr == A_MARK),
        .hold_full(hold_full), .active(tx_active), .line(tx_line)
    );

    uart_mp_rx #(.DW(DW), .OSR(OSR)) i_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(ctrl_q[C_RXEN]),
        .par_en(ctrl_q[C_PAR]), .par_odd(ctrl_q[C_ODD]), .line(rx_line),
        .deliver(rx_deliver), .data(rx_byte), .mark(rx_mark),
        .perr(rx_perr), .ferr(rx_ferr)
    );

    // configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            loop_q <= 1'b0;
            div_q  <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL:  ctrl_q        <= reg_wdata[CTRL_W-1:0];
                A_CTRLX: loop_q        <= reg_wdata[0];
                A_DIVL:  div_q[7:0]    <= reg_wdata;
                A_DIVH:  div_q[15:8]   <= reg_wdata;
                default: ;
            endcase
        end
    end

    // two-flop synchronizer on the external receive line
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_sync <= 2'b11;
        else        rxd_sync <= {rxd_sync[0], rxd};
    end

    // serial output register with break forcing
    always_ff @(posedge clk) begin
        if (!rst_n) txd <= 1'b1;
        else        txd <= ctrl_q[C_BRK] ? 1'b0 : tx_line;
    end

    // receive status: read of the data register clears, a new byte wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_q   <= '0;
            rx_valid_q  <= 1'b0;
            new_frame_q <= 1'b0;
            mark_last_q <= 1'b0;
            perr_q      <= 1'b0;
            ferr_q      <= 1'b0;
        end else if (rx_deliver) begin
            rx_data_q   <= rx_byte;
            rx_valid_q  <= 1'b1;
            new_frame_q <= rx_mark;
            mark_last_q <= rx_mark;
            perr_q      <= rx_perr;
            ferr_q      <= rx_ferr;
        end else if (rd_data) begin
            rx_valid_q  <= 1'b0;
            new_frame_q <= 1'b0;
            mark_last_q <= 1'b0;
            perr_q      <= 1'b0;
            ferr_q      <= 1'b0;
        end
    end

    // read data multiplexer
    always_comb begin
        unique case (reg_addr)
            A_DATA:  reg_rdata = rx_data_q;
            A_STAT:  reg_rdata = {1'b0, ferr_q, perr_q, mark_last_q, new_frame_q,
                                  tx_active, hold_full, rx_valid_q};
            A_CTRL:  reg_rdata = {1'b0, ctrl_q};
            A_DIVL:  reg_rdata = div_q[7:0];
            A_DIVH:  reg_rdata = div_q[15:8];
            A_CTRLX: reg_rdata = {7'b0, loop_q};
            default: reg_rdata = '0;
        endcase
    end

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_deliver) |=> (!rx_ready && !new_frame_q && !mark_last_q))
        else $error("rd_clear_chk");

    // R7
    brk_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[C_BRK] |=> !txd)
        else $error("brk_line_chk");

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRLX || reg_addr == A_CTRL) |-> (reg_rdata[7] == 1'b0))
        else $error("rsvd_zero_chk");
endmodule

// File: tb/test_uart_mp.sv
module test_uart_mp;
    import uart_mp_pkg::*;

    localparam int DIV = 2;
    localparam int BIT = 16 * DIV;
    localparam logic [7:0] TXEN = 8'h01, RXEN = 8'h02, CTSG = 8'h04, PAR = 8'h08,
                           ODD = 8'h10, BRK = 8'h20, STP2 = 8'h40;

    logic clk = 1'b0, rst_n;
    logic [2:0] reg_addr;
    logic reg_wr, reg_rd, rxd, cts_n, txd, rx_ready;
    logic [7:0] reg_wdata, reg_rdata;

    always #10 clk = ~clk;

    uart_mp i_uart_mp (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd),
        .cts_n(cts_n), .rx_ready(rx_ready)
    );

    typedef struct { logic [7:0] d; logic mk; logic pe; logic fe; } exp_t;
    exp_t sb[$];
    int n_cmp = 0, n_bad = 0;
    bit bus_lock = 0, done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        while (bus_lock) @(negedge clk);
        bus_lock = 1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; bus_lock = 0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        while (bus_lock) @(negedge clk);
        bus_lock = 1;
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; bus_lock = 0;
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        bus_wr(A_CTRL, 8'h00);
        bus_wr(A_CTRL, v);
    endtask

    // driver: waits for a free holding register, then queues and writes
    task automatic push_tx(input logic [7:0] d, input logic mk, input bit expect_rx);
        logic [7:0] st;
        int lim = 0;
        do begin
            bus_rd(A_STAT, st);
            lim++;
        end while (st[1] && lim < 2000);
        if (expect_rx) sb.push_back('{d: d, mk: mk, pe: 1'b0, fe: 1'b0});
        bus_wr(mk ? A_MARK : A_DATA, d);
    endtask

    task automatic wait_idle(input string req);
        int lim = 0;
        while (sb.size() != 0 && lim < 4000) begin
            @(negedge clk);
            lim++;
        end
        chk({req, " scoreboard drained"}, sb.size(), 0);
        repeat (60) @(negedge clk);
    endtask

    // drives one frame on rxd; bad_stop holds the stop low for 12 ticks
    task automatic rx_frame(input logic [7:0] d, input logic mk, input bit par_on,
                            input bit odd, input bit flip, input bit bad_stop);
        rxd = 1'b0; repeat (BIT) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rxd = d[k]; repeat (BIT) @(negedge clk);
        end
        if (par_on) begin
            rxd = (^d) ^ odd ^ flip; repeat (BIT) @(negedge clk);
        end
        rxd = mk; repeat (BIT) @(negedge clk);
        if (bad_stop) begin
            rxd = 1'b0; repeat (12 * DIV) @(negedge clk);
        end
        rxd = 1'b1; repeat (3 * BIT) @(negedge clk);
    endtask

    task automatic capture(input int nb, output logic [15:0] bits);
        int lim = 0;
        bits = '0;
        while (txd && lim < 3000) begin
            @(negedge clk);
            lim++;
        end
        for (int k = 0; k < nb; k++) begin
            repeat (k == 0 ? BIT / 2 : BIT) @(negedge clk);
            bits[k] = txd;
        end
    endtask

    // monitor: pops the expected item whenever a byte is ready
    initial begin : monitor
        logic [7:0] st, d, st2;
        exp_t e;
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            if (rx_ready) begin
                bus_rd(A_STAT, st);
                bus_rd(A_DATA, d);
                bus_rd(A_STAT, st2);
                if (sb.size() == 0) begin
                    chk("R11 R8 unexpected byte", {24'd0, d}, 32'hFFFF_FFFF);
                end else begin
                    e = sb.pop_front();
                    chk("R5 data", d, e.d);
                    chk("R6 ready bit", st[0], 1'b1);
                    chk("R6 marker bit", st[4], e.mk);
                    chk("R6 new-message bit", st[3], e.mk);
                    chk("R4 parity error", st[5], e.pe);
                    chk("R9 framing error", st[6], e.fe);
                    chk("R6 cleared after read", {st2[6:3], st2[0]}, 5'b0);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin : main
        logic [7:0] v;
        logic [15:0] bits;
        int cnt;
        bit low_seen;
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        rxd = 1'b1; cts_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(A_CTRL, v);  chk("R1 ctrl", v, 8'h00);
        bus_rd(A_CTRLX, v); chk("R1 ctrlx", v, 8'h00);
        bus_rd(A_STAT, v);  chk("R1 status", v, 8'h00);
        chk("R1 txd idle", txd, 1'b1);
        chk("R1 rx_ready", rx_ready, 1'b0);

        // R10 reserved bits
        bus_wr(A_CTRL, 8'h80);  bus_rd(A_CTRL, v);  chk("R10 ctrl bit7", v, 8'h00);
        bus_wr(A_CTRLX, 8'hFE); bus_rd(A_CTRLX, v); chk("R10 ctrlx 7..1", v, 8'h00);

        bus_wr(A_DIVL, 8'(DIV));
        bus_wr(A_DIVH, 8'h00);
        bus_wr(A_CTRLX, 8'h01);

        // R12 bit length: 0x01 gives a start bit alone at low level
        set_ctrl(TXEN | RXEN);
        push_tx(8'h01, 1'b1, 1);
        while (txd) @(negedge clk);
        cnt = 1;
        forever begin
            @(negedge clk);
            if (txd) break;
            cnt++;
        end
        chk("R12 start bit cycles", cnt, BIT);
        wait_idle("R12");

        // R5 R4 line order with even parity, two stops
        set_ctrl(TXEN | RXEN | PAR | STP2);
        push_tx(8'hA5, 1'b0, 1);
        capture(13, bits);
        chk("R5 R4 even two-stop frame", bits[12:0], {2'b11, 1'b0, ^8'hA5, 8'hA5, 1'b0});
        wait_idle("R5");

        // R4 R5 odd parity, one stop, marker set
        set_ctrl(TXEN | RXEN | PAR | ODD);
        push_tx(8'h07, 1'b1, 1);
        capture(12, bits);
        chk("R4 R5 odd frame", bits[11:0], {1'b1, 1'b1, ~(^8'h07), 8'h07, 1'b0});
        wait_idle("R4");

        // R2 gating holds the byte
        set_ctrl(TXEN | RXEN | CTSG);
        cts_n = 1'b1;
        push_tx(8'h3C, 1'b0, 1);
        low_seen = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (!txd) low_seen = 1;
        end
        chk("R2 held while cts_n high", low_seen, 1'b0);
        bus_rd(A_STAT, v);
        chk("R2 holding full", v[2:1], 2'b01);
        cts_n = 1'b0;
        wait_idle("R2 release");

        // R2 gating raised while a character is on the line
        push_tx(8'h11, 1'b1, 1);
        push_tx(8'h22, 1'b0, 1);
        cts_n = 1'b1;
        repeat (900) @(negedge clk);
        chk("R2 second byte still queued", sb.size(), 1);
        bus_rd(A_STAT, v);
        chk("R2 second byte held", v[2:1], 2'b01);
        cts_n = 1'b0;
        wait_idle("R2 coincidence");

        // R3 gating disabled: cts_n ignored
        set_ctrl(TXEN | RXEN);
        cts_n = 1'b1;
        push_tx(8'h5A, 1'b1, 1);
        wait_idle("R3");
        cts_n = 1'b0;

        // R7 break
        set_ctrl(BRK);
        repeat (3) @(negedge clk);
        low_seen = 1;
        for (int i = 0; i < 100; i++) begin
            if (txd) low_seen = 0;
            @(negedge clk);
        end
        chk("R7 txd low during break", low_seen, 1'b1);
        set_ctrl(8'h00);
        repeat (3) @(negedge clk);
        chk("R7 txd high after break", txd, 1'b1);

        // R11 receiver disabled
        set_ctrl(TXEN);
        bus_wr(A_DATA, 8'h99);
        repeat (600) @(negedge clk);
        chk("R11 no byte with receiver off", rx_ready, 1'b0);

        // R8 loopback ignores rxd
        set_ctrl(RXEN);
        rx_frame(8'h55, 1'b0, 0, 0, 0, 0);
        repeat (40) @(negedge clk);
        chk("R8 rxd ignored in loopback", rx_ready, 1'b0);

        // R5 R4 R9 direct frames on rxd
        set_ctrl(8'h00);
        bus_wr(A_CTRLX, 8'h00);
        set_ctrl(RXEN | PAR);
        sb.push_back('{d: 8'h3A, mk: 1'b1, pe: 1'b0, fe: 1'b0});
        rx_frame(8'h3A, 1'b1, 1, 0, 0, 0);
        wait_idle("R5 rx order");
        sb.push_back('{d: 8'h6B, mk: 1'b1, pe: 1'b1, fe: 1'b0});
        rx_frame(8'h6B, 1'b1, 1, 0, 1, 0);
        wait_idle("R4 parity error");
        sb.push_back('{d: 8'h12, mk: 1'b0, pe: 1'b0, fe: 1'b1});
        rx_frame(8'h12, 1'b0, 1, 0, 0, 1);
        wait_idle("R9 framing error");
        set_ctrl(RXEN | PAR | ODD);
        sb.push_back('{d: 8'hC3, mk: 1'b0, pe: 1'b0, fe: 1'b0});
        rx_frame(8'hC3, 1'b0, 1, 1, 0, 0);
        wait_idle("R4 odd receive");

        report();
    end
endmodule